// File: doc/BRIEF.md
# Synchronous Burst Read Address Sequencer

This block sits in front of a word-wide memory array and turns one address-valid strobe into the sequence of word addresses for a synchronous burst read. On the strobe it captures a start address and decodes a 16-bit configuration word. The word selects the wrap order, the burst length, the first-access latency, the polarity and timing of the WAIT pin, and the clock edge on which outputs are presented. After the programmed latency the block raises data-valid and steps through the burst, one word per clock. A suspend input can hold the burst at any point.

The control is a four-state machine. IDLE: no burst is running. LATENCY: the first-access count runs down. STREAM: one word per cycle is delivered with data-valid high. BOUNDARY: a one-cycle gap in continuous mode when the next word opens a new aligned 16-word row. The transitions are as follows. A synchronous strobe moves any state to LATENCY (launch, or restart when a burst is running). An asynchronous-mode strobe moves any state to IDLE (abort). LATENCY moves to STREAM when the count expires. STREAM moves to BOUNDARY on a row crossing. BOUNDARY moves back to STREAM after one cycle. STREAM moves to IDLE when a wrapping burst completes. Suspend blocks every transition except the two that a strobe causes.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, data-valid is 0, the address output is 0 and WAIT sits at its inactive (low) level.
- R2: A strobe with configuration bit 15 at 0 starts a burst. From the next cycle the address output shows the start address. Data-valid first rises L cycles after the strobe edge, where L is configuration bits 13:11. Codes 0 and 1 act as 2.
- R3: With bit 7 = 1 (sequential) and bits 2:0 = 1, 2 or 3 (4, 8 or 16 words), the address counts up and wraps inside the aligned group holding the start address. For example, start 7 with 4 words gives 7,4,5,6. Data-valid falls after the last word and the address holds.
- R4: With bit 7 = 0 (interleaved), word j of a wrapping burst is the start offset XOR j inside the aligned group. For example, start 1 with 4 words gives 1,0,3,2.
- R5: Bits 2:0 = 7, or any code other than 1 to 3, give a continuous linear burst. When the next word starts a new aligned 16-word row, one cycle is inserted in which the address already shows the new word and data-valid is 0 (13,14,15,gap,16).
- R6: With bit 8 = 0, WAIT is asserted in every cycle of a running burst in which data-valid is 0: latency, row gap and suspend.
- R7: With bit 8 = 1, WAIT leads by one cycle. It is asserted during every latency cycle except the last, and during the valid word before a row gap. It is not asserted in the row gap itself.
- R8: Bit 10 = 1 makes WAIT active high. Bit 10 = 0 makes it active low, so the idle level is high.
- R9: A strobe with bit 15 = 1 starts no burst and ends any burst in progress. Data-valid stays 0 and WAIT stays inactive.
- R10: While suspend is 1, data-valid is 0, the address and the latency count hold, and WAIT is asserted. The burst resumes from the same word.
- R11: A synchronous strobe during a burst abandons it and restarts with a fresh latency count from the new start address.
- R12: With bit 6 = 0, the address, data-valid and WAIT outputs change on the falling clock edge instead of the rising one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Burst clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| adv_valid | input | 1 | Address-valid strobe; captures the start address and configuration |
| start_addr | input | AW | Word address of the first burst word |
| cfg_word | input | 16 | Configuration word, decoded on the strobe |
| burst_suspend | input | 1 | Holds the burst while high |
| rd_addr | output | AW | Current word address |
| data_valid | output | 1 | Current word is valid |
| wait_pin | output | 1 | WAIT indication at the programmed polarity |

## Verification
Two events can land on the same cycle: suspend, and the expiry of the latency count that would otherwise present the first word. The bench raises suspend in exactly the cycle the first word becomes due. It then expects data-valid low, WAIT asserted and the same word to reappear once suspend drops. A second collision, a new strobe arriving while a word is being delivered, is provoked mid-stream. It is judged by the fresh latency from the new start address, with no further word from the old burst.

// File: rtl/burst_seq_pkg.sv
`timescale 1ns/1ps
package burst_seq_pkg;

    localparam int ROW_WORDS = 16;
    localparam int ROW_BITS  = $clog2(ROW_WORDS);

    localparam int CFG_W      = 16;
    localparam int CFG_ASYNC  = 15;
    localparam int CFG_LAT_HI = 13;
    localparam int CFG_LAT_LO = 11;
    localparam int CFG_POL    = 10;
    localparam int CFG_EARLY  = 8;
    localparam int CFG_ORDER  = 7;
    localparam int CFG_EDGE   = 6;
    localparam int LAT_W      = CFG_LAT_HI - CFG_LAT_LO + 1;
    localparam logic [LAT_W-1:0] MIN_LAT = LAT_W'(2);

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_LATENCY,
        SEQ_STREAM,
        SEQ_BOUNDARY
    } seq_state_e;

    typedef enum logic [1:0] {
        BL_4,
        BL_8,
        BL_16,
        BL_CONT
    } burst_len_e;

    typedef struct packed {
        logic             seq_order;
        burst_len_e       blen;
        logic [LAT_W-1:0] lat;
        logic             wait_hi;
        logic             wait_early;
        logic             rise_edge;
    } burst_cfg_t;

    localparam burst_cfg_t CFG_RESET = '{
        seq_order:  1'b1,
        blen:       BL_CONT,
        lat:        MIN_LAT,
        wait_hi:    1'b1,
        wait_early: 1'b0,
        rise_edge:  1'b1
    };

    function automatic burst_cfg_t decode_cfg(input logic [CFG_W-1:0] w);
        burst_cfg_t c;
        c.seq_order  = w[CFG_ORDER];
        c.wait_hi    = w[CFG_POL];
        c.wait_early = w[CFG_EARLY];
        c.rise_edge  = w[CFG_EDGE];
        c.lat        = (w[CFG_LAT_HI:CFG_LAT_LO] < MIN_LAT) ? MIN_LAT
                                                            : w[CFG_LAT_HI:CFG_LAT_LO];
        case (w[2:0])
            3'd1:    c.blen = BL_4;
            3'd2:    c.blen = BL_8;
            3'd3:    c.blen = BL_16;
            default: c.blen = BL_CONT;
        endcase
        return c;
    endfunction

    function automatic logic [ROW_BITS-1:0] row_mask(input burst_len_e b);
        case (b)
            BL_4:    return ROW_BITS'(3);
            BL_8:    return ROW_BITS'(7);
            default: return ROW_BITS'(ROW_WORDS - 1);
        endcase
    endfunction

endpackage

// File: rtl/bseq_addr_map.sv
`timescale 1ns/1ps
module bseq_addr_map
    import burst_seq_pkg::*;
#(
    parameter int AW = 22
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] idx,
    input  burst_cfg_t    cfg,
    output logic [AW-1:0] addr
);

    logic [ROW_BITS-1:0] mask;
    logic [ROW_BITS-1:0] seq_off;
    logic [ROW_BITS-1:0] xor_off;
    logic [ROW_BITS-1:0] off;
    logic [ROW_BITS-1:0] low;
    logic [AW-1:0]       linear;

    always_comb begin
        mask    = row_mask(cfg.blen);
        seq_off = base[ROW_BITS-1:0] + idx[ROW_BITS-1:0];
        xor_off = base[ROW_BITS-1:0] ^ idx[ROW_BITS-1:0];
        off     = cfg.seq_order ? seq_off : xor_off;
        low     = (base[ROW_BITS-1:0] & ~mask) | (off & mask);
        linear  = base + idx;
        if (cfg.blen == BL_CONT) begin
            addr = linear;
        end else begin
            addr = {base[AW-1:ROW_BITS], low};
        end
    end

endmodule

// File: rtl/bseq_wait_gen.sv
`timescale 1ns/1ps
module bseq_wait_gen (
    input  logic active,
    input  logic in_latency,
    input  logic lat_last,
    input  logic in_stream,
    input  logic boundary_next,
    input  logic suspend,
    input  logic data_ok,
    input  logic early,
    input  logic wait_hi,
    output logic wait_act,
    output logic wait_lvl
);

    logic now_term;
    logic ahead_term;

    always_comb begin
        now_term   = active && !data_ok;
        ahead_term = active && (suspend
                              || (in_latency && !lat_last)
                              || (in_stream && boundary_next));
        wait_act   = early ? ahead_term : now_term;
        wait_lvl   = wait_hi ? wait_act : !wait_act;
    end

endmodule

// File: rtl/bseq_edge_stage.sv
`timescale 1ns/1ps
module bseq_edge_stage #(
    parameter int AW = 22
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rise_sel,
    input  logic [AW-1:0] addr_in,
    input  logic          dv_in,
    input  logic          wait_in,
    output logic [AW-1:0] addr_out,
    output logic          dv_out,
    output logic          wait_out
);

    logic [AW-1:0] addr_f;
    logic          dv_f;
    logic          wait_f;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_f <= '0;
            dv_f   <= 1'b0;
            wait_f <= 1'b0;
        end else begin
            addr_f <= addr_in;
            dv_f   <= dv_in;
            wait_f <= wait_in;
        end
    end

    always_comb begin
        if (rise_sel) begin
            addr_out = addr_in;
            dv_out   = dv_in;
            wait_out = wait_in;
        end else begin
            addr_out = addr_f;
            dv_out   = dv_f;
            wait_out = wait_f;
        end
    end

endmodule

// File: rtl/burst_addr_seq.sv
`timescale 1ns/1ps
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int AW = 22
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv_valid,
    input  logic [AW-1:0] start_addr,
    input  logic [15:0]   cfg_word,
    input  logic          burst_suspend,
    output logic [AW-1:0] rd_addr,
    output logic          data_valid,
    output logic          wait_pin
);

    seq_state_e       state_q;
    seq_state_e       state_d;
    burst_cfg_t       cfg_q;
    burst_cfg_t       cfg_new;
    logic [AW-1:0]    base_q;
    logic [AW-1:0]    idx_q;
    logic [LAT_W-1:0] lat_q;

    logic [AW-1:0]    core_addr;
    logic             core_dv;
    logic             wait_act;
    logic             wait_lvl;
    logic             sync_launch;
    logic             async_hit;
    logic             wrap_mode;
    logic             wrap_last;
    logic             boundary_next;
    logic             lat_last;
    logic             early_sel;

    assign cfg_new     = decode_cfg(cfg_word);
    assign sync_launch = adv_valid && !cfg_word[CFG_ASYNC];
    assign async_hit   = adv_valid && cfg_word[CFG_ASYNC];
    assign wrap_mode   = (cfg_q.blen != BL_CONT);
    assign wrap_last   = (idx_q[ROW_BITS-1:0] == row_mask(cfg_q.blen));
    assign lat_last    = (lat_q == '0);
    assign early_sel   = cfg_q.wait_early;

    bseq_addr_map #(.AW(AW)) u_map (
        .base (base_q),
        .idx  (idx_q),
        .cfg  (cfg_q),
        .addr (core_addr)
    );

    assign boundary_next = !wrap_mode && (&core_addr[ROW_BITS-1:0]);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (sync_launch) begin
            state_d = SEQ_LATENCY;
        end else if (async_hit) begin
            state_d = SEQ_IDLE;
        end else if (!burst_suspend) begin
            unique case (state_q)
                SEQ_IDLE: begin
                    state_d = SEQ_IDLE;
                end
                SEQ_LATENCY: begin
                    if (lat_last) state_d = SEQ_STREAM;
                end
                SEQ_STREAM: begin
                    if (wrap_mode && wrap_last) begin
                        state_d = SEQ_IDLE;
                    end else if (boundary_next) begin
                        state_d = SEQ_BOUNDARY;
                    end
                end
                SEQ_BOUNDARY: begin
                    state_d = SEQ_STREAM;
                end
            endcase
        end
    end

    // burst context: start, word index, latency count, captured fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            idx_q  <= '0;
            lat_q  <= '0;
            cfg_q  <= CFG_RESET;
        end else if (sync_launch) begin
            base_q <= start_addr;
            idx_q  <= '0;
            lat_q  <= cfg_new.lat - LAT_W'(1);
            cfg_q  <= cfg_new;
        end else if (!async_hit && !burst_suspend) begin
            if (state_q == SEQ_LATENCY && !lat_last) begin
                lat_q <= lat_q - LAT_W'(1);
            end
            if (state_q == SEQ_STREAM && !(wrap_mode && wrap_last)) begin
                idx_q <= idx_q + AW'(1);
            end
        end
    end

    // outputs
    always_comb begin
        core_dv = 1'b0;
        unique case (state_q)
            SEQ_IDLE:     core_dv = 1'b0;
            SEQ_LATENCY:  core_dv = 1'b0;
            SEQ_STREAM:   core_dv = !burst_suspend;
            SEQ_BOUNDARY: core_dv = 1'b0;
        endcase
    end

    bseq_wait_gen u_wait (
        .active        (state_q != SEQ_IDLE),
        .in_latency    (state_q == SEQ_LATENCY),
        .lat_last      (lat_last),
        .in_stream     (state_q == SEQ_STREAM),
        .boundary_next (boundary_next),
        .suspend       (burst_suspend),
        .data_ok       (core_dv),
        .early         (cfg_q.wait_early),
        .wait_hi       (cfg_q.wait_hi),
        .wait_act      (wait_act),
        .wait_lvl      (wait_lvl)
    );

    bseq_edge_stage #(.AW(AW)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_sel (cfg_q.rise_edge),
        .addr_in  (core_addr),
        .dv_in    (core_dv),
        .wait_in  (wait_lvl),
        .addr_out (rd_addr),
        .dv_out   (data_valid),
        .wait_out (wait_pin)
    );

endmodule

// File: rtl/bseq_checker.sv
`timescale 1ns/1ps
module bseq_checker #(
    parameter int AW = 22
) (
    input logic          clk,
    input logic          rst_n,
    input logic          adv_valid,
    input logic [AW-1:0] start_addr,
    input logic [15:0]   cfg_word,
    input logic          burst_suspend,
    input logic [AW-1:0] core_addr,
    input logic          core_dv,
    input logic          wrap_mode
);

    // R2: a synchronous strobe shows its start address next cycle, data not yet valid
    assert_strobe_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_valid && !cfg_word[15]) |=> (core_addr == $past(start_addr)) && !core_dv);

    // R3: consecutive valid words of a wrapping burst stay inside one 16-word row
    assert_wrap_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (core_dv && $past(core_dv) && wrap_mode) |-> (core_addr[AW-1:4] == $past(core_addr[AW-1:4])));

    // R5: consecutive valid words of a continuous burst step by one
    assert_cont_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (core_dv && $past(core_dv) && !wrap_mode) |-> (core_addr == $past(core_addr) + AW'(1)));

    // R9: an asynchronous-mode strobe never yields a valid word next cycle
    assert_async_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_valid && cfg_word[15]) |=> !core_dv);

    // R10: suspend freezes the word address
    assert_suspend_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_suspend && !adv_valid) |=> $stable(core_addr));

endmodule

bind burst_addr_seq bseq_checker #(.AW(AW)) u_bseq_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .adv_valid     (adv_valid),
    .start_addr    (start_addr),
    .cfg_word      (cfg_word),
    .burst_suspend (burst_suspend),
    .core_addr     (core_addr),
    .core_dv       (core_dv),
    .wrap_mode     (wrap_mode)
);

// File: tb/tb_burst_addr_seq.sv
`timescale 1ns/1ps
module tb_burst_addr_seq;

    localparam int AW = 22;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          adv_valid = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [15:0]   cfg_word = 16'h8000;
    logic          burst_suspend = 1'b0;
    logic [AW-1:0] rd_addr;
    logic          data_valid;
    logic          wait_pin;

    typedef struct {
        int    cyc;
        int    addr;
        bit    chk_addr;
        bit    dv;
        bit    wpin;
        string req;
    } sb_item_t;

    sb_item_t sbq[$];
    sb_item_t mon_it;
    int cyc = 0;
    int n_cmp = 0;
    int n_bad = 0;

    burst_addr_seq #(.AW(AW)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .adv_valid     (adv_valid),
        .start_addr    (start_addr),
        .cfg_word      (cfg_word),
        .burst_suspend (burst_suspend),
        .rd_addr       (rd_addr),
        .data_valid    (data_valid),
        .wait_pin      (wait_pin)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compare every expected item in its cycle, after the falling edge
    always begin
        @(posedge clk);
        #4;
        while (sbq.size() > 0 && sbq[0].cyc <= cyc) begin
            mon_it = sbq.pop_front();
            n_cmp++;
            if (mon_it.cyc != cyc || data_valid !== mon_it.dv || wait_pin !== mon_it.wpin
                || (mon_it.chk_addr && rd_addr !== AW'(mon_it.addr))) begin
                n_bad++;
                $display("FAIL %s cycle %0d: addr %h dv %b wait %b, expected addr %h dv %b wait %b",
                         mon_it.req, cyc, rd_addr, data_valid, wait_pin,
                         AW'(mon_it.addr), mon_it.dv, mon_it.wpin);
            end
        end
    end

    function automatic logic [15:0] mk_cfg(bit asyn, int lat, bit pol, bit early,
                                           bit seq, bit rise, int len);
        logic [15:0] w = '0;
        w[15]    = asyn;
        w[13:11] = 3'(lat);
        w[10]    = pol;
        w[8]     = early;
        w[7]     = seq;
        w[6]     = rise;
        w[2:0]   = 3'(len);
        return w;
    endfunction

    task automatic sb_push(int c, int a, bit ca, bit v, bit w, string r);
        sb_item_t it;
        it.cyc = c; it.addr = a; it.chk_addr = ca; it.dv = v; it.wpin = w; it.req = r;
        sbq.push_back(it);
    endtask

    task automatic idle(int c);
        repeat (c) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic qcheck(bit ok, string r, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", r, act, exp);
        end
    endtask

    // driver: strobe a synchronous burst and queue K cycles of expected output
    // N = 0 selects the continuous model
    task automatic launch(logic [15:0] cw, int s, int L, int N, bit seq, bit early,
                          bit pol, int K, string req);
        int a[$];
        bit v[$];
        bit w[$];
        int n0 = cyc;
        for (int k = 0; k < L; k++) begin
            a.push_back(s); v.push_back(1'b0); w.push_back(early ? (k < L - 1) : 1'b1);
        end
        if (N > 0) begin
            int base = s & ~(N - 1);
            int off  = s & (N - 1);
            int last = s;
            for (int j = 0; j < N; j++) begin
                int o = seq ? ((off + j) % N) : (off ^ j);
                last = base + o;
                a.push_back(last); v.push_back(1'b1); w.push_back(1'b0);
            end
            while (a.size() < K) begin
                a.push_back(last); v.push_back(1'b0); w.push_back(1'b0);
            end
        end else begin
            int cur = s;
            a.push_back(cur); v.push_back(1'b1); w.push_back(1'b0);
            while (a.size() < K) begin
                int nxt = cur + 1;
                if (nxt % 16 == 0) begin
                    if (early) w[w.size() - 1] = 1'b1;
                    a.push_back(nxt); v.push_back(1'b0); w.push_back(!early);
                end
                a.push_back(nxt); v.push_back(1'b1); w.push_back(1'b0);
                cur = nxt;
            end
        end
        for (int k = 0; k < K; k++) begin
            sb_push(n0 + 1 + k, a[k], 1'b1, v[k], pol ? w[k] : !w[k], req);
        end
        adv_valid  = 1'b1;
        cfg_word   = cw;
        start_addr = AW'(s);
        @(posedge clk);
        #1;
        adv_valid  = 1'b0;
    endtask

    task automatic launch_async(int K, bit pol, string req);
        int n0 = cyc;
        for (int k = 0; k < K; k++) sb_push(n0 + 1 + k, 0, 1'b0, 1'b0, !pol, req);
        adv_valid  = 1'b1;
        cfg_word   = mk_cfg(1, 2, 1, 0, 1, 1, 1);
        start_addr = AW'(22'h155);
        @(posedge clk);
        #1;
        adv_valid  = 1'b0;
    endtask

    initial begin
        int n0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1: reset state
        qcheck(data_valid == 1'b0, "R1 data_valid", data_valid, 0);
        qcheck(wait_pin == 1'b0, "R1 wait_pin", wait_pin, 0);
        qcheck(rd_addr == '0, "R1 rd_addr", rd_addr, 0);

        // R3/R2: sequential 4-word wraps
        launch(mk_cfg(0, 3, 1, 0, 1, 1, 1), 1, 3, 4, 1, 0, 1, 8, "R3 seq4 start1");  idle(7);
        launch(mk_cfg(0, 2, 1, 0, 1, 1, 1), 7, 2, 4, 1, 0, 1, 7, "R3 seq4 start7");  idle(6);
        launch(mk_cfg(0, 4, 1, 0, 1, 1, 3), 'h2A, 4, 16, 1, 0, 1, 21, "R3 seq16");  idle(20);
        // R4: interleaved
        launch(mk_cfg(0, 2, 1, 0, 0, 1, 1), 1, 2, 4, 0, 0, 1, 7, "R4 intl4 start1"); idle(6);
        launch(mk_cfg(0, 2, 1, 0, 0, 1, 1), 7, 2, 4, 0, 0, 1, 7, "R4 intl4 start7"); idle(6);
        launch(mk_cfg(0, 2, 1, 0, 0, 1, 2), 5, 2, 8, 0, 0, 1, 11, "R4 intl8");      idle(10);
        launch(mk_cfg(0, 2, 1, 0, 0, 1, 3), 'h3B, 2, 16, 0, 0, 1, 19, "R4 intl16"); idle(18);
        // R5/R6: continuous with row gap, WAIT during the gap
        launch(mk_cfg(0, 2, 1, 0, 1, 1, 7), 13, 2, 0, 1, 0, 1, 10, "R5/R6 cont13"); idle(9);
        launch(mk_cfg(0, 2, 1, 0, 1, 1, 5), 'h1E, 2, 0, 1, 0, 1, 8, "R5 cont code5"); idle(7);
        // R7: early WAIT
        launch(mk_cfg(0, 4, 1, 1, 1, 1, 7), 29, 4, 0, 1, 1, 1, 12, "R7 early cont"); idle(11);
        // R8: active-low WAIT
        launch(mk_cfg(0, 3, 0, 0, 1, 1, 2), 2, 3, 8, 1, 0, 0, 12, "R8 pol low");    idle(11);
        // R2: latency code clamp and maximum
        launch(mk_cfg(0, 0, 1, 0, 1, 1, 1), 4, 2, 4, 1, 0, 1, 7, "R2 lat code0");   idle(6);
        launch(mk_cfg(0, 7, 1, 0, 1, 1, 1), 4, 7, 4, 1, 0, 1, 12, "R2 lat code7");  idle(11);
        // R9: asynchronous strobe aborts a burst in latency
        launch(mk_cfg(0, 5, 1, 0, 1, 1, 3), 0, 5, 16, 1, 0, 1, 3, "R9 pre-abort"); idle(2);
        launch_async(8, 1, "R9 async"); idle(7);

        // R10: suspend lands on the cycle the first word is due
        launch(mk_cfg(0, 2, 1, 0, 1, 1, 1), 8, 2, 4, 1, 0, 1, 2, "R10 latency");
        n0 = cyc - 1;
        idle(2);
        burst_suspend = 1'b1;
        sb_push(n0 + 3, 8, 1, 0, 1, "R10 suspended");
        sb_push(n0 + 4, 8, 1, 0, 1, "R10 suspended");
        idle(2);
        burst_suspend = 1'b0;
        sb_push(n0 + 5, 8, 1, 1, 0, "R10 resume");
        sb_push(n0 + 6, 9, 1, 1, 0, "R10 resume");
        sb_push(n0 + 7, 10, 1, 1, 0, "R10 resume");
        sb_push(n0 + 8, 11, 1, 1, 0, "R10 resume");
        sb_push(n0 + 9, 11, 1, 0, 0, "R10 end");
        idle(5);

        // R11: restart mid-stream
        launch(mk_cfg(0, 3, 1, 0, 1, 1, 2), 'h10, 3, 8, 1, 0, 1, 5, "R11 first"); idle(4);
        launch(mk_cfg(0, 2, 1, 0, 0, 1, 1), 'h21, 2, 4, 0, 0, 1, 7, "R11 restart"); idle(6);

        // R12: falling-edge presentation
        launch(mk_cfg(0, 2, 1, 0, 1, 0, 1), 'h40, 2, 4, 1, 0, 1, 7, "R12 fall");
        idle(2);
        qcheck(data_valid == 1'b0, "R12 dv before falling edge", data_valid, 0);
        qcheck(rd_addr == AW'('h40), "R12 addr before falling edge", rd_addr, 'h40);
        idle(4);

        idle(3);
        qcheck(sbq.size() == 0, "scoreboard drained", sbq.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule